// File: doc/BRIEF.md
# Reset Generation and Cause Logger

This block issues power-on resets and externally initiated resets to the processors of a small multiprocessor system, together with a whole-system reset. Software starts resets by writing single bytes to a small set of control registers. Hardware requesters also start resets: a watchdog expiry line, two buttons, debug-port requests, per-agent fatal-error lines, a power-up indication, a remote monitor and a clock-synthesizer load pin. Every reset comes out as a pulse of fixed width.

Two independent cause registers show what caused the latest reset. One covers the power-on-reset class and the other covers the interrupt-reset class. On each new event the affected register drops its old contents and takes only the causes of that event. Causes that arrive in the same cycle are merged, except that a power-up always stands alone. Configuration registers decide whether a watchdog expiry is acted on, whether fatal errors from the first four agents are reported, and whether the synthesizer load pin may reset the system.

All inputs are synchronous to `clk`, and each request is sampled as a level on every clock. The asynchronous reset is released through a two-stage synchronizer.

Top module: `reset_cause_logger`

## Requirements
- R1: After reset all reset outputs are low, both cause registers read zero, the watchdog is ignored, no fatal agent is masked and the synthesizer reset is disabled.
- R2: A write to select 0 (soft power-on reset) with data bit i set (i in 0..3) drives `cpu_por_o[i]` high for exactly 16 cycles. The pulse starts in the cycle after the write is sampled. The power-on cause then reads only bits 3:0 of the written data.
- R3: A write to select 0 with data bit 4 set drives `sys_rst_o` and all four `cpu_por_o` bits high for 16 cycles, and the power-on cause reads 0x10.
- R4: Bits 7:5 written to select 0 and bits 7:4 written to select 1 have no effect: no output pulses and no cause register changes.
- R5: A write to select 1 (soft interrupt reset) with data bit i set (i in 0..3) drives `cpu_xir_o[i]` high for 16 cycles, and the interrupt cause reads bits 3:0 of the written data.
- R6: `dbg_xir_req_i` pulses all four `cpu_xir_o` bits and sets interrupt cause 0x10. `xir_button_i` does the same and sets interrupt cause 0x20. Interrupt cause bits 7:6 stay zero.
- R7: Bit 0 of select 2 enables the watchdog. When it is clear, `wdog_expire_i` has no effect. When it is set, an expiry resets the system and sets power-on cause 0x10000 (bit 16).
- R8: Fatal line k resets the system and sets power-on cause bit 8+k. Bit 4+k of select 3 (k in 0..3) masks agent k, so that its line neither resets nor logs. Agents 4..6 cannot be masked.
- R9: When bit 7 of select 4 is set, a high `synth_load_i` resets the system and sets power-on cause bit 15. When that bit is clear, the pin has no effect.
- R10: `power_up_i` resets the system and leaves the power-on cause at exactly 0x80, even when other causes arrive in the same cycle.
- R11: Each new event replaces the affected cause register with the causes of that event only. Causes that arrive in the same cycle are OR-ed together.
- R12: `rst_button_i` logs bit 6, `dbg_por_req_i` logs bit 5 and `remote_rst_i` logs bit 17. Each of them resets the system.
- R13: An interrupt-reset event leaves the power-on cause and `cpu_por_o` untouched, and a power-on event leaves the interrupt cause untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 soft power-on, 1 soft interrupt, 2 watchdog, 3 quiesce, 4 synthesizer |
| wr_data | input | 8 | Write byte |
| wdog_expire_i | input | 1 | Watchdog timer expired |
| rst_button_i | input | 1 | System reset button |
| xir_button_i | input | 1 | Interrupt reset button |
| dbg_por_req_i | input | 1 | Debug-port system reset request |
| dbg_xir_req_i | input | 1 | Debug-port interrupt reset request |
| fatal_i | input | 7 | Fatal-error lines from seven agents |
| power_up_i | input | 1 | Power-up indication |
| remote_rst_i | input | 1 | Remote monitor reset request |
| synth_load_i | input | 1 | Clock synthesizer load pin |
| cpu_por_o | output | 4 | Per-processor power-on reset |
| cpu_xir_o | output | 4 | Per-processor interrupt reset |
| sys_rst_o | output | 1 | System reset |
| por_cause_o | output | 18 | Power-on reset cause |
| xir_cause_o | output | 8 | Interrupt reset cause |

## Verification
The bench builds the block with its default parameters: four processors, seven fatal agents of which four can be masked, and a 16-cycle pulse. This gives the 18-bit power-on cause layout and the 8-bit interrupt layout. It also makes the pulse edges at cycles 16 and 17 after a request directly observable. With these values every cause bit, the mask boundary between agent 3 and agent 4, and the override of coincident causes by power-up can each be reached by one directed request.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  typedef enum logic [2:0] {
    SEL_SOFT_POR  = 3'd0,
    SEL_SOFT_XIR  = 3'd1,
    SEL_WDOG_ACT  = 3'd2,
    SEL_QUIESCE   = 3'd3,
    SEL_SYNTH_CTL = 3'd4
  } reg_sel_e;

  localparam int WR_W = 8;
endpackage

// File: rtl/rcl_rst_sync.sv
module rcl_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= stage_d;
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/rcl_pulse_chan.sv
module rcl_pulse_chan #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH - 1);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // a new request restarts the window
  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (trig) begin
      act_d  = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (act_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/rcl_cfg.sv
module rcl_cfg #(
  parameter int NMASK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdog_we,
  input  logic             quiesce_we,
  input  logic             synth_we,
  input  logic [7:0]       wr_data,
  output logic             wdog_en,
  output logic [NMASK-1:0] fatal_mask,
  output logic             synth_en
);
  logic             wdog_q, wdog_d;
  logic [NMASK-1:0] mask_q, mask_d;
  logic             synth_q, synth_d;

  always_comb begin
    wdog_d  = wdog_we    ? wr_data[0]           : wdog_q;
    mask_d  = quiesce_we ? wr_data[4 +: NMASK]  : mask_q;
    synth_d = synth_we   ? wr_data[7]           : synth_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdog_q  <= 1'b0;
      mask_q  <= '0;
      synth_q <= 1'b0;
    end else begin
      if (wdog_we)    wdog_q  <= wdog_d;
      if (quiesce_we) mask_q  <= mask_d;
      if (synth_we)   synth_q <= synth_d;
    end
  end

  assign wdog_en    = wdog_q;
  assign fatal_mask = mask_q;
  assign synth_en   = synth_q;
endmodule

// File: rtl/rcl_cause_log.sv
module rcl_cause_log #(
  parameter int POR_W   = 18,
  parameter int XIR_W   = 8,
  parameter int PWR_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POR_W-1:0] por_evt,
  input  logic [XIR_W-1:0] xir_evt,
  output logic [POR_W-1:0] por_cause,
  output logic [XIR_W-1:0] xir_cause
);
  logic [POR_W-1:0] por_q, por_d;
  logic [XIR_W-1:0] xir_q, xir_d;
  logic             por_ld, xir_ld;

  always_comb begin
    por_ld = |por_evt;
    xir_ld = |xir_evt;
    // power-up stands alone in the log
    if (por_evt[PWR_BIT]) por_d = POR_W'(1) << PWR_BIT;
    else                  por_d = por_evt;
    xir_d = xir_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= '0;
      xir_q <= '0;
    end else begin
      if (por_ld) por_q <= por_d;
      if (xir_ld) xir_q <= xir_d;
    end
  end

  assign por_cause = por_q;
  assign xir_cause = xir_q;
endmodule

// File: rtl/reset_cause_logger.sv
module reset_cause_logger #(
  parameter int NCPU    = 4,
  parameter int NFATAL  = 7,
  parameter int NMASK   = 4,
  parameter int PULSE_W = 16,
  localparam int POR_W  = NCPU + 4 + NFATAL + 3,
  localparam int XIR_W  = NCPU + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              wdog_expire_i,
  input  logic              rst_button_i,
  input  logic              xir_button_i,
  input  logic              dbg_por_req_i,
  input  logic              dbg_xir_req_i,
  input  logic [NFATAL-1:0] fatal_i,
  input  logic              power_up_i,
  input  logic              remote_rst_i,
  input  logic              synth_load_i,
  output logic [NCPU-1:0]   cpu_por_o,
  output logic [NCPU-1:0]   cpu_xir_o,
  output logic              sys_rst_o,
  output logic [POR_W-1:0]  por_cause_o,
  output logic [XIR_W-1:0]  xir_cause_o
);
  import rcl_pkg::*;

  localparam int B_SYS = NCPU;
  localparam int B_DBG = NCPU + 1;
  localparam int B_BTN = NCPU + 2;
  localparam int B_PWR = NCPU + 3;
  localparam int B_FE0 = NCPU + 4;
  localparam int B_SYN = B_FE0 + NFATAL;
  localparam int B_WDG = B_SYN + 1;
  localparam int B_RMT = B_SYN + 2;
  localparam int X_DBG = NCPU;
  localparam int X_BTN = NCPU + 1;

  logic              rst_n_s;
  logic              spor_we, sxir_we, wdog_we, quiesce_we, synth_we;
  logic              wdog_en, synth_en;
  logic [NMASK-1:0]  fatal_mask;
  logic [NFATAL-1:0] fatal_ok;
  logic [POR_W-1:0]  por_evt;
  logic [XIR_W-1:0]  xir_evt;
  logic              sys_trig;
  logic              xir_all;
  logic              sys_act;
  logic [NCPU-1:0]   por_act;
  logic [NCPU-1:0]   xir_act;

  rcl_rst_sync u_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  always_comb begin
    spor_we    = wr_en && (wr_sel == SEL_SOFT_POR);
    sxir_we    = wr_en && (wr_sel == SEL_SOFT_XIR);
    wdog_we    = wr_en && (wr_sel == SEL_WDOG_ACT);
    quiesce_we = wr_en && (wr_sel == SEL_QUIESCE);
    synth_we   = wr_en && (wr_sel == SEL_SYNTH_CTL);
  end

  rcl_cfg #(.NMASK(NMASK)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wdog_we    (wdog_we),
    .quiesce_we (quiesce_we),
    .synth_we   (synth_we),
    .wr_data    (wr_data),
    .wdog_en    (wdog_en),
    .fatal_mask (fatal_mask),
    .synth_en   (synth_en)
  );

  always_comb begin
    fatal_ok = fatal_i & ~{{(NFATAL-NMASK){1'b0}}, fatal_mask};

    por_evt              = '0;
    por_evt[NCPU-1:0]    = spor_we ? wr_data[NCPU-1:0] : '0;
    por_evt[B_SYS]       = spor_we & wr_data[NCPU];
    por_evt[B_DBG]       = dbg_por_req_i;
    por_evt[B_BTN]       = rst_button_i;
    por_evt[B_PWR]       = power_up_i;
    por_evt[B_FE0 +: NFATAL] = fatal_ok;
    por_evt[B_SYN]       = synth_en & synth_load_i;
    por_evt[B_WDG]       = wdog_en & wdog_expire_i;
    por_evt[B_RMT]       = remote_rst_i;
    sys_trig             = |por_evt[POR_W-1:B_SYS];

    xir_evt              = '0;
    xir_evt[NCPU-1:0]    = sxir_we ? wr_data[NCPU-1:0] : '0;
    xir_evt[X_DBG]       = dbg_xir_req_i;
    xir_evt[X_BTN]       = xir_button_i;
    xir_all              = xir_evt[X_DBG] | xir_evt[X_BTN];
  end

  rcl_pulse_chan #(.WIDTH(PULSE_W)) u_sys_chan (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .trig   (sys_trig),
    .active (sys_act)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    rcl_pulse_chan #(.WIDTH(PULSE_W)) u_por_chan (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .trig   (por_evt[i]),
      .active (por_act[i])
    );
    rcl_pulse_chan #(.WIDTH(PULSE_W)) u_xir_chan (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .trig   (xir_evt[i] | xir_all),
      .active (xir_act[i])
    );
  end

  rcl_cause_log #(.POR_W(POR_W), .XIR_W(XIR_W), .PWR_BIT(B_PWR)) u_log (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .por_evt   (por_evt),
    .xir_evt   (xir_evt),
    .por_cause (por_cause_o),
    .xir_cause (xir_cause_o)
  );

  assign sys_rst_o = sys_act;
  assign cpu_por_o = por_act | {NCPU{sys_act}};
  assign cpu_xir_o = xir_act;
endmodule

// File: rtl/reset_cause_logger_chk.sv
module reset_cause_logger_chk #(
  parameter int NCPU    = 4,
  parameter int PULSE_W = 16,
  parameter int POR_W   = 18,
  parameter int XIR_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCPU-1:0]  cpu_por_o,
  input logic [NCPU-1:0]  cpu_xir_o,
  input logic             sys_rst_o,
  input logic [POR_W-1:0] por_cause_o,
  input logic [XIR_W-1:0] xir_cause_o
);
  localparam int B_PWR = NCPU + 3;
  localparam int RW    = $clog2(PULSE_W + 2) + 1;
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!sys_rst_o)     run_q <= '0;
    else if (run_q != RMAX)  run_q <= run_q + 1'b1;
  end

  assert_sys_all_cpus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (&cpu_por_o));

  assert_sys_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (int'(run_q) >= PULSE_W));

  assert_por_log_with_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(por_cause_o) |-> (|cpu_por_o));

  assert_xir_log_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xir_cause_o) |-> (|cpu_xir_o));

  assert_powerup_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    por_cause_o[B_PWR] |-> ($countones(por_cause_o) == 1));
endmodule

bind reset_cause_logger reset_cause_logger_chk #(
  .NCPU(NCPU), .PULSE_W(PULSE_W), .POR_W(POR_W), .XIR_W(XIR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_por_o   (cpu_por_o),
  .cpu_xir_o   (cpu_xir_o),
  .sys_rst_o   (sys_rst_o),
  .por_cause_o (por_cause_o),
  .xir_cause_o (xir_cause_o)
);

// File: tb/reset_cause_logger_test.sv
module reset_cause_logger_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic        wdog_expire_i, rst_button_i, xir_button_i;
  logic        dbg_por_req_i, dbg_xir_req_i;
  logic [6:0]  fatal_i;
  logic        power_up_i, remote_rst_i, synth_load_i;
  logic [3:0]  cpu_por_o, cpu_xir_o;
  logic        sys_rst_o;
  logic [17:0] por_cause_o;
  logic [7:0]  xir_cause_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  reset_cause_logger uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wdog_expire_i(wdog_expire_i), .rst_button_i(rst_button_i),
    .xir_button_i(xir_button_i), .dbg_por_req_i(dbg_por_req_i),
    .dbg_xir_req_i(dbg_xir_req_i), .fatal_i(fatal_i), .power_up_i(power_up_i),
    .remote_rst_i(remote_rst_i), .synth_load_i(synth_load_i),
    .cpu_por_o(cpu_por_o), .cpu_xir_o(cpu_xir_o), .sys_rst_o(sys_rst_o),
    .por_cause_o(por_cause_o), .xir_cause_o(xir_cause_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    wr_en = 0; wr_sel = 0; wr_data = 0;
    wdog_expire_i = 0; rst_button_i = 0; xir_button_i = 0;
    dbg_por_req_i = 0; dbg_xir_req_i = 0; fatal_i = 0;
    power_up_i = 0; remote_rst_i = 0; synth_load_i = 0;
  endtask

  // drives one write; returns at the negedge after the sampling edge
  task automatic write_reg(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    clear_inputs();
  endtask

  // called at the first negedge after the request edge
  task automatic check_window(input string tag, input logic [3:0] por,
                              input logic [3:0] xir, input logic sys);
    check({tag, " start por"}, 32'(cpu_por_o), 32'(por));
    check({tag, " start xir"}, 32'(cpu_xir_o), 32'(xir));
    check({tag, " start sys"}, 32'(sys_rst_o), 32'(sys));
    repeat (15) @(negedge clk);
    check({tag, " cycle16 por"}, 32'(cpu_por_o), 32'(por));
    check({tag, " cycle16 xir"}, 32'(cpu_xir_o), 32'(xir));
    @(negedge clk);
    check({tag, " end por"}, 32'(cpu_por_o), 32'h0);
    check({tag, " end xir"}, 32'(cpu_xir_o), 32'h0);
    check({tag, " end sys"}, 32'(sys_rst_o), 32'h0);
  endtask

  task automatic check_quiet(input string tag, input logic [17:0] pc, input logic [7:0] xc);
    check({tag, " no por"}, 32'(cpu_por_o), 32'h0);
    check({tag, " no xir"}, 32'(cpu_xir_o), 32'h0);
    check({tag, " no sys"}, 32'(sys_rst_o), 32'h0);
    check({tag, " por cause kept"}, 32'(por_cause_o), 32'(pc));
    check({tag, " xir cause kept"}, 32'(xir_cause_o), 32'(xc));
  endtask

  task automatic t_reset_R1();
    check("R1 por", 32'(cpu_por_o), 0);
    check("R1 xir", 32'(cpu_xir_o), 0);
    check("R1 sys", 32'(sys_rst_o), 0);
    check("R1 por cause", 32'(por_cause_o), 0);
    check("R1 xir cause", 32'(xir_cause_o), 0);
    @(negedge clk); wdog_expire_i = 1; synth_load_i = 1; fatal_i = 7'h01;
    @(negedge clk); clear_inputs();
    check("R1 defaults sys", 32'(sys_rst_o), 1);
    check("R1 defaults cause", 32'(por_cause_o), 32'h00100);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_soft_por_R2();
    write_reg(3'd0, 8'h05);
    check("R2 cause", 32'(por_cause_o), 32'h5);
    check_window("R2", 4'b0101, 4'b0000, 1'b0);
  endtask

  task automatic t_reserved_R4();
    write_reg(3'd0, 8'hE0);
    check_quiet("R4 spor", 18'h5, 8'h0);
    write_reg(3'd1, 8'hF0);
    check_quiet("R4 sxir", 18'h5, 8'h0);
    repeat (3) @(negedge clk);
    check_quiet("R4 later", 18'h5, 8'h0);
  endtask

  task automatic t_soft_sys_R3();
    write_reg(3'd0, 8'h10);
    check("R3 cause", 32'(por_cause_o), 32'h10);
    check_window("R3", 4'b1111, 4'b0000, 1'b1);
  endtask

  task automatic t_soft_xir_R5();
    write_reg(3'd1, 8'h0A);
    check("R5 cause", 32'(xir_cause_o), 32'h0A);
    check("R13 por cause untouched", 32'(por_cause_o), 32'h10);
    check_window("R5", 4'b0000, 4'b1010, 1'b0);
  endtask

  task automatic t_xir_all_R6();
    @(negedge clk); dbg_xir_req_i = 1;
    @(negedge clk); clear_inputs();
    check("R6 dbg cause", 32'(xir_cause_o), 32'h10);
    check_window("R6 dbg", 4'b0000, 4'b1111, 1'b0);
    @(negedge clk); xir_button_i = 1;
    @(negedge clk); clear_inputs();
    check("R6 button cause", 32'(xir_cause_o), 32'h20);
    check("R13 por cause still", 32'(por_cause_o), 32'h10);
    check_window("R6 button", 4'b0000, 4'b1111, 1'b0);
  endtask

  task automatic t_wdog_R7();
    @(negedge clk); wdog_expire_i = 1;
    @(negedge clk); clear_inputs();
    check_quiet("R7 gated", 18'h10, 8'h20);
    write_reg(3'd2, 8'h01);
    @(negedge clk); wdog_expire_i = 1;
    @(negedge clk); clear_inputs();
    check("R7 cause", 32'(por_cause_o), 32'h10000);
    check("R13 xir cause kept", 32'(xir_cause_o), 32'h20);
    check_window("R7", 4'b1111, 4'b0000, 1'b1);
  endtask

  task automatic t_misc_R12();
    @(negedge clk); rst_button_i = 1;
    @(negedge clk); clear_inputs();
    check("R12 button", 32'(por_cause_o), 32'h40);
    check("R12 button sys", 32'(sys_rst_o), 1);
    repeat (20) @(negedge clk);
    @(negedge clk); dbg_por_req_i = 1;
    @(negedge clk); clear_inputs();
    check("R12 debug", 32'(por_cause_o), 32'h20);
    repeat (20) @(negedge clk);
    @(negedge clk); remote_rst_i = 1;
    @(negedge clk); clear_inputs();
    check("R12 remote", 32'(por_cause_o), 32'h20000);
    check_window("R12 remote", 4'b1111, 4'b0000, 1'b1);
  endtask

  task automatic t_fatal_R8();
    @(negedge clk); fatal_i = 7'h01;
    @(negedge clk); clear_inputs();
    check("R8 agent0", 32'(por_cause_o), 32'h100);
    repeat (20) @(negedge clk);
    write_reg(3'd3, 8'h10);
    @(negedge clk); fatal_i = 7'h01;
    @(negedge clk); clear_inputs();
    check_quiet("R8 agent0 masked", 18'h100, 8'h20);
    write_reg(3'd3, 8'hF0);
    @(negedge clk); fatal_i = 7'h08;
    @(negedge clk); clear_inputs();
    check_quiet("R8 agent3 masked", 18'h100, 8'h20);
    @(negedge clk); fatal_i = 7'h40;
    @(negedge clk); clear_inputs();
    check("R8 agent6 unmaskable", 32'(por_cause_o), 32'h4000);
    check_window("R8", 4'b1111, 4'b0000, 1'b1);
    write_reg(3'd3, 8'h00);
  endtask

  task automatic t_synth_R9();
    @(negedge clk); synth_load_i = 1;
    @(negedge clk); clear_inputs();
    check_quiet("R9 disabled", 18'h4000, 8'h20);
    write_reg(3'd4, 8'h80);
    @(negedge clk); synth_load_i = 1;
    @(negedge clk); clear_inputs();
    check("R9 cause", 32'(por_cause_o), 32'h8000);
    check_window("R9", 4'b1111, 4'b0000, 1'b1);
  endtask

  task automatic t_recent_R11();
    @(negedge clk); rst_button_i = 1; remote_rst_i = 1;
    @(negedge clk); clear_inputs();
    check("R11 merged", 32'(por_cause_o), 32'h20040);
    repeat (20) @(negedge clk);
    write_reg(3'd0, 8'h02);
    check("R11 replaced", 32'(por_cause_o), 32'h2);
    check_window("R11", 4'b0010, 4'b0000, 1'b0);
  endtask

  task automatic t_powerup_R10();
    @(negedge clk); power_up_i = 1; rst_button_i = 1; fatal_i = 7'h10;
    @(negedge clk); clear_inputs();
    check("R10 cause alone", 32'(por_cause_o), 32'h80);
    check_window("R10", 4'b1111, 4'b0000, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset_R1();
    t_soft_por_R2();
    t_reserved_R4();
    t_soft_sys_R3();
    t_soft_xir_R5();
    t_xir_all_R6();
    t_wdog_R7();
    t_misc_R12();
    t_fatal_R8();
    t_synth_R9();
    t_recent_R11();
    t_powerup_R10();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule